// File: doc/BRIEF.md
# Preamble-Qualified Bit Error Counter

This block sits at the receive end of a link test. Multi-bit converter samples come in as two's-complement words. A slicer turns each sample into a hard bit, either by comparing it against a programmable level or by reading its sign. The first decisions taken while the start-pattern window is open are gathered four at a time and checked against a fixed four-bit initialization word. A wrong word raises a resend request to the far end. A bounded run of wrong words declares the channel faulty.

Once the word has matched, the block waits for a load pulse. The pulse seeds a local four-stage pseudo-random generator with a fixed value. From then on, every decided bit is compared with the generator's output bit, and each disagreement adds one to a saturating error counter. The sample input is a valid/ready stream. The block never applies back-pressure: ready is high in every cycle, and each cycle with valid high consumes one sample. All other pins are plain levels or pulses.

Top module: `bert_qualified_rx`

## Requirements
- R1: With `slice_sign` low, samples and `level` are read as signed two's-complement. A sample strictly greater than `level` decides 1. A sample equal to or below `level` decides 0.
- R2: With `slice_sign` high, the decided bit is the inverse of the sample's top bit. A zero or positive sample decides 1 and a negative sample decides 0.
- R3: While waiting for the initialization word, a bit is collected only in a cycle where `smp_valid` and `pat_window` are both high. The earliest of the four bits lands in bit 3 of the word. Any cycle with `pat_window` low discards a partly collected word.
- R4: If the four collected bits equal 4'b1011, `pat_ok` goes to 1 and `pat_err` goes to 0 at the edge that takes the fourth bit. Both then hold until reset.
- R5: If the collected word differs from 4'b1011 and fewer than four failures came before, `pat_err` goes to 1 and `pat_ok` goes to 0. `resend_req` pulses for exactly one cycle, and collection starts over.
- R6: The fifth failed word sets `chan_fault` and raises no resend request. `chan_fault` stays set until reset, and all later input is ignored.
- R7: A `seed_load` pulse has no effect unless the word has matched and the generator has not been seeded yet.
- R8: Bits decided after the match and before seeding leave the error counter unchanged. So does a bit offered in the same cycle as the seeding pulse.
- R9: Seeding loads the generator state with 4'b0001. For each later valid bit, the reference is state bit 3. The state then shifts left, and the new bit 0 is bit 3 XOR bit 2. Every disagreement between the decided bit and the reference adds 1 to `err_count` at that edge.
- R10: `err_count` stops at its all-ones value and does not wrap.
- R11: Reset returns the block to waiting for the word. It clears the failure tally, the error count and all flags.
- R12: `smp_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | 14 | Two's-complement sample |
| smp_valid | input | 1 | Sample present this cycle |
| smp_ready | output | 1 | Always high; no back-pressure |
| level | input | 14 | Signed decision level for level mode |
| slice_sign | input | 1 | 1 selects sign decision, 0 selects level decision |
| pat_window | input | 1 | High while the initialization word may arrive |
| seed_load | input | 1 | Pulse that seeds the local generator |
| pat_ok | output | 1 | Initialization word matched |
| pat_err | output | 1 | Latest initialization word was wrong |
| resend_req | output | 1 | One-cycle request to resend the word |
| chan_fault | output | 1 | Sticky: too many failed words |
| err_count | output | 32 | Saturating count of bit errors |

## Verification
The properties assume reset is asserted before the first observed edge. They also assume the far end honours the resend request by sending whole four-bit words, so that two resend pulses are never closer than four cycles apart. The stimulus keeps to this because collection only restarts after a completed word, and the bench never produces a word in fewer than four sample cycles. The error-count properties assume that seeding happens at most once per qualification. The bench pulses the load only as the block's rules allow, apart from the deliberately ignored pulses.

// File: rtl/bq_pkg.sv
package bq_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } bq_state_e;
endpackage

// File: rtl/bq_slicer.sv
module bq_slicer #(
  parameter int SMP_W = 14
) (
  input  logic [SMP_W-1:0] smp,
  input  logic [SMP_W-1:0] thr,
  input  logic             sign_mode,
  output logic             bit_o
);
  logic above;
  assign above = ($signed(smp) > $signed(thr));
  // sign decision: non-negative -> 1, negative -> 0
  assign bit_o = sign_mode ? ~smp[SMP_W-1] : above;
endmodule

// File: rtl/bq_preamble.sv
module bq_preamble
  import bq_pkg::*;
#(
  parameter int              PAT_W     = 4,
  parameter logic [PAT_W-1:0] PATTERN  = 4'b1011,
  parameter int              MAX_TRIES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_val,
  input  logic window,
  input  logic load,
  output logic pat_ok,
  output logic pat_err,
  output logic resend_req,
  output logic chan_fault,
  output logic lfsr_load,
  output logic cmp_en
);
  localparam int CNT_BITS = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam int TRY_W    = $clog2(MAX_TRIES + 1);
  localparam logic [CNT_BITS-1:0] LAST_IDX = CNT_BITS'(PAT_W - 1);
  localparam logic [TRY_W-1:0]    TRY_LIM  = TRY_W'(MAX_TRIES);

  bq_state_e          state_q;
  logic [PAT_W-1:0]   sr_q;
  logic [PAT_W-1:0]   sr_nx;
  logic [CNT_BITS-1:0] cnt_q;
  logic [TRY_W-1:0]   tries_q;

  assign sr_nx     = {sr_q[PAT_W-2:0], bit_val};
  assign lfsr_load = (state_q == ST_ARMED) && load;
  assign cmp_en    = (state_q == ST_RUN) && bit_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_WAIT;
      sr_q       <= '0;
      cnt_q      <= '0;
      tries_q    <= '0;
      pat_ok     <= 1'b0;
      pat_err    <= 1'b0;
      resend_req <= 1'b0;
      chan_fault <= 1'b0;
    end else begin
      resend_req <= 1'b0;
      unique case (state_q)
        ST_WAIT: begin
          if (!window) begin
            cnt_q <= '0;
          end else if (bit_vld) begin
            sr_q <= sr_nx;
            if (cnt_q == LAST_IDX) begin
              cnt_q <= '0;
              if (sr_nx == PATTERN) begin
                pat_ok  <= 1'b1;
                pat_err <= 1'b0;
                state_q <= ST_ARMED;
              end else begin
                pat_ok  <= 1'b0;
                pat_err <= 1'b1;
                if (tries_q == TRY_LIM) begin
                  chan_fault <= 1'b1;
                  state_q    <= ST_FAULT;
                end else begin
                  tries_q    <= tries_q + 1'b1;
                  resend_req <= 1'b1;
                end
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_ARMED: if (load) state_q <= ST_RUN;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bq_lfsr.sv
module bq_lfsr #(
  parameter int             W     = 4,
  parameter logic [W-1:0]   SEED  = 4'b0001,
  parameter int             TAP_A = 3,
  parameter int             TAP_B = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic ref_bit
);
  logic [W-1:0] st_q;
  assign ref_bit = st_q[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    st_q <= SEED;
    else if (load) st_q <= SEED;
    else if (step) st_q <= {st_q[W-2:0], st_q[TAP_A] ^ st_q[TAP_B]};
  end
endmodule

// File: rtl/bq_errcnt.sv
module bq_errcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;
  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (inc && count != TOP)  count <= count + 1'b1;
  end
endmodule

// File: rtl/bert_qualified_rx.sv
module bert_qualified_rx #(
  parameter int SMP_W = 14,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] level,
  input  logic             slice_sign,
  input  logic             pat_window,
  input  logic             seed_load,
  output logic             pat_ok,
  output logic             pat_err,
  output logic             resend_req,
  output logic             chan_fault,
  output logic [CNT_W-1:0] err_count
);
  logic dec_bit, cmp_en, lfsr_load, ref_bit;

  assign smp_ready = 1'b1;

  bq_slicer #(.SMP_W(SMP_W)) u_slice (
    .smp(smp_data), .thr(level), .sign_mode(slice_sign), .bit_o(dec_bit)
  );

  bq_preamble u_pre (
    .clk(clk), .rst_n(rst_n), .bit_vld(smp_valid), .bit_val(dec_bit),
    .window(pat_window), .load(seed_load),
    .pat_ok(pat_ok), .pat_err(pat_err), .resend_req(resend_req),
    .chan_fault(chan_fault), .lfsr_load(lfsr_load), .cmp_en(cmp_en)
  );

  bq_lfsr u_ref (
    .clk(clk), .rst_n(rst_n), .load(lfsr_load), .step(cmp_en), .ref_bit(ref_bit)
  );

  bq_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cmp_en && (dec_bit ^ ref_bit)), .count(err_count)
  );
endmodule

// File: rtl/bq_checker.sv
module bq_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pat_ok,
  input logic             pat_err,
  input logic             resend_req,
  input logic             chan_fault,
  input logic [CNT_W-1:0] err_count
);
  logic seen_q;
  always_ff @(posedge clk) seen_q <= rst_n;

  a_r4_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pat_ok && pat_err));
  a_r5_resend_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |=> !resend_req);
  a_r5_resend_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |-> (pat_err && !pat_ok));
  a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    chan_fault |=> chan_fault);
  a_r6_fault_no_resend: assert property (@(posedge clk) disable iff (!rst_n)
    chan_fault |-> (!resend_req && !pat_ok));
  a_r8_no_count_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_ok |-> (err_count == '0));
  a_r10_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1)));
  a_r4_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pat_ok |=> pat_ok);
endmodule

bind bert_qualified_rx bq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pat_ok(pat_ok), .pat_err(pat_err),
  .resend_req(resend_req), .chan_fault(chan_fault), .err_count(err_count)
);

// File: tb/bert_qualified_rx_test.sv
module bert_qualified_rx_test;
  localparam logic [3:0] PAT  = 4'b1011;
  localparam logic [3:0] SEED = 4'b0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] smp_data = '0;
  logic        smp_valid = 1'b0;
  logic [13:0] level = '0;
  logic        slice_sign = 1'b0;
  logic        pat_window = 1'b0;
  logic        seed_load = 1'b0;
  logic        smp_ready, pat_ok, pat_err, resend_req, chan_fault;
  logic [31:0] err_count;
  logic        s_ready, s_ok, s_err, s_resend, s_fault;
  logic [3:0]  s_count;

  int checks = 0, errors = 0;
  // reference model state
  int m_state = 0, m_cnt = 0, m_tries = 0;
  logic [3:0] m_sr = '0, m_lfsr = SEED;
  logic m_ok = 0, m_err = 0, m_fault = 0, m_resend = 0;
  longint m_errs = 0;

  always #5 clk = ~clk;

  bert_qualified_rx uut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .level(level), .slice_sign(slice_sign),
    .pat_window(pat_window), .seed_load(seed_load), .pat_ok(pat_ok),
    .pat_err(pat_err), .resend_req(resend_req), .chan_fault(chan_fault),
    .err_count(err_count)
  );

  bert_qualified_rx #(.CNT_W(4)) uut_small (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(s_ready), .level(level), .slice_sign(slice_sign),
    .pat_window(pat_window), .seed_load(seed_load), .pat_ok(s_ok),
    .pat_err(s_err), .resend_req(s_resend), .chan_fault(s_fault),
    .err_count(s_count)
  );

  function automatic logic decide(logic [13:0] s, logic [13:0] t, logic sm);
    if (sm) return (s[13] == 1'b0);
    return ($signed(s) > $signed(t));
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_state = 0; m_cnt = 0; m_tries = 0; m_sr = '0; m_lfsr = SEED;
    m_ok = 0; m_err = 0; m_fault = 0; m_resend = 0; m_errs = 0;
  endtask

  task automatic model_step();
    logic b;
    b = decide(smp_data, level, slice_sign);
    m_resend = 0;
    case (m_state)
      0: begin
        if (!pat_window) m_cnt = 0;
        else if (smp_valid) begin
          m_sr = {m_sr[2:0], b};
          if (m_cnt == 3) begin
            m_cnt = 0;
            if (m_sr == PAT) begin m_ok = 1; m_err = 0; m_state = 1; end
            else begin
              m_ok = 0; m_err = 1;
              if (m_tries == 4) begin m_fault = 1; m_state = 3; end
              else begin m_tries++; m_resend = 1; end
            end
          end else m_cnt++;
        end
      end
      1: if (seed_load) begin m_lfsr = SEED; m_state = 2; end
      2: if (smp_valid) begin
        if (b ^ m_lfsr[3]) m_errs++;
        m_lfsr = {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
      end
      default: ;
    endcase
  endtask

  task automatic check_all(string tag);
    chk({tag, " R12 ready"}, smp_ready & s_ready, 1);
    chk({tag, " R4 pat_ok"}, pat_ok, m_ok);
    chk({tag, " R5 pat_err"}, pat_err, m_err);
    chk({tag, " R5 resend_req"}, resend_req, m_resend);
    chk({tag, " R6 chan_fault"}, chan_fault, m_fault);
    chk({tag, " R9 err_count"}, err_count, m_errs);
    chk({tag, " R10 saturated count"}, s_count, (m_errs > 15) ? 15 : m_errs);
  endtask

  // called at a negedge with inputs already set
  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic put(logic [13:0] s, logic v, logic w, logic ld, string tag);
    smp_data = s; smp_valid = v; pat_window = w; seed_load = ld;
    cyc(tag);
  endtask

  task automatic do_reset();
    rst_n = 0; smp_valid = 0; seed_load = 0; pat_window = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    model_reset();
    check_all("R11 reset");
    rst_n = 1;
  endtask

  // send a 4-bit word in level mode with level=100 (1 -> 101, 0 -> 100)
  task automatic send_word(logic [3:0] w, string tag);
    for (int i = 3; i >= 0; i--) put(w[i] ? 14'd101 : 14'd100, 1, 1, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();
    level = 14'd100; slice_sign = 0;
    // R7: load before qualification is ignored
    put(14'd0, 0, 0, 1, "R7 early load");
    // R1: samples equal to level decide 0 -> word 0000 fails, R5 resend
    send_word(4'b0000, "R1 R5 equal-level fail");
    // R3: partial word dropped when window falls; invalid cycles skipped
    put(14'd101, 1, 1, 0, "R3 partial");
    put(14'd101, 1, 1, 0, "R3 partial");
    put(14'd0, 1, 0, 0, "R3 window low");
    put(14'd101, 0, 1, 0, "R3 invalid");
    // R1 negative sample below level decides 0 in middle of word
    put(14'd101, 1, 1, 0, "R1 word");
    put(14'h3FFB, 1, 1, 0, "R1 negative");
    put(14'd101, 1, 1, 0, "R1 word");
    put(14'd101, 1, 1, 0, "R4 pass");
    chk("R4 qualified", pat_ok, 1);
    // R8: bits before seeding ignored
    for (int i = 0; i < 6; i++) put(14'h2000, 1, 0, 0, "R8 pre-seed");
    put(14'h2000, 1, 0, 1, "R8 load cycle bit");
    chk("R8 count after load", err_count, 0);
    // R2 directed: sign mode, zero decides 1
    slice_sign = 1;
    put(14'd0, 1, 0, 0, "R2 zero");
    put(14'h3FFF, 1, 0, 0, "R2 negative");
    // R7: second load ignored once running (no reseed)
    put(14'd5, 1, 0, 1, "R7 late load");
    // random run, R9 and R10
    for (int i = 0; i < 800; i++) begin
      slice_sign = 1'($urandom % 2);
      level = 14'($urandom);
      put(14'($urandom), ($urandom % 4) != 0, 1'($urandom % 2),
          ($urandom % 16) == 0, "R9 random");
    end
    chk("R10 small counter pinned", s_count, 15);
    // R11: reset mid-run
    do_reset();
    chk("R11 count cleared", err_count, 0);
    // R6: five failures then fault
    level = 14'd100; slice_sign = 0;
    for (int k = 0; k < 5; k++) send_word(4'b0100, "R6 failing word");
    chk("R6 fault set", chan_fault, 1);
    send_word(PAT, "R6 ignored after fault");
    chk("R6 still no ok", pat_ok, 0);
    for (int i = 0; i < 3; i++) put(14'd7, 1, 0, 1, "R6 idle");
    do_reset();
    // a few random qualification words with retries
    for (int k = 0; k < 6; k++) begin
      logic [3:0] w;
      w = (k == 5) ? PAT : 4'($urandom);
      send_word(w, "R5 random word");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule